// File: doc/BRIEF.md
# ISA Variant Selector with Per-Variant Trap Vectors

This block is a machine-mode CSR unit. It keeps a writable pair of identifiers, one for the vendor and one for the architecture. The pair chooses which instruction-encoding variant the decoder applies. A small table of legal pairs maps each supported pair to a variant index. The index goes to the decoder and also selects a bank of trap-vector registers. There is one machine trap vector and one supervisor trap vector per variant.

Software changes the variant in two writes. It first writes the vendor identifier, which is only staged. It then writes the architecture identifier. If the staged vendor and the written architecture form a legal pair, a switch starts. The switch raises the stall output and waits for the decoder's ready signal. The new index commits in the cycle that ready is seen, and the stall then holds for a fixed drain period.

Trap requests that arrive while the stall is high are held back. They are taken once the stall clears, so no trap ever uses a vector set that disagrees with the decode variant. Taking a trap never alters the active pair, and a switch never alters any stored vector.

Top module: `isa_variant_csr`

## Requirements
- R1: After reset the variant index is 0, stall is low, no trap is taken, and both identifier CSRs read 0. Machine vector entry i reads 0x1000 + i*0x100, and supervisor vector entry i reads 0x2000 + i*0x100.
- R2: A write to the architecture CSR (address 0xF12) that forms a legal pair with the staged vendor raises stall_o from the next cycle. The variant index stays unchanged until decode_ready_i is seen high while stalled.
- R3: A write to the architecture CSR that forms an unsupported pair starts no switch. Stall stays low and the active pair is unchanged.
- R4: The new variant index appears in the cycle after a stalled cycle with decode_ready_i high. stall_o then stays high for exactly 2 further cycles and drops.
- R5: Reading the vendor CSR (0xF11) and the architecture CSR (0xF12) returns the active pair. A staged vendor value that has not been committed is not visible. The legal pairs, given as index: (vendor, arch), are 0: (0, 0), 1: (0x489, 1), 2: (0x489, 0x80000002), 3: (0x612, 5).
- R6: Reads and writes of the machine vector CSR (0x305) reach only the entry of the active variant. Bits 1:0 of a stored vector are always zero.
- R7: Reads and writes of the supervisor vector CSR (0x105) reach only the entry of the active variant, with bits 1:0 forced to zero.
- R8: When not stalled, a trap request is taken in the same cycle. trap_pc_o gives the active machine vector, or the active supervisor vector when trap_to_s_i is high.
- R9: trap_take_o is never high while stall_o is high. One request arriving during a stall is held. It is taken, with its machine or supervisor kind kept, in the first cycle after the stall clears, and it uses the vectors of the new variant.
- R10: Taking a trap leaves the variant index unchanged.
- R11: A variant switch changes no stored vector entry of any variant.
- R12: Writes to either identifier CSR while stall_o is high are ignored. This applies both to the staged vendor and to the start of a switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data for csr_addr_i; 0 for other addresses |
| decode_ready_i | input | 1 | Decoder ready to accept a variant change |
| trap_req_i | input | 1 | Single-cycle trap request |
| trap_to_s_i | input | 1 | Trap targets the supervisor vector |
| trap_take_o | output | 1 | Trap taken this cycle |
| trap_pc_o | output | XLEN | Trap target address |
| variant_o | output | IDXW | Active decode variant index |
| stall_o | output | 1 | Pipeline stall during a variant switch |

## Verification
Two functions can fall in the same cycle: a trap request can arrive while a variant switch is in progress. The bench pulses a supervisor trap while the switch waits for decoder ready, then releases ready. It checks that nothing is taken during the stall. It also checks that the held trap is taken in exactly the first cycle after the stall. That trap must carry the supervisor vector of the newly selected variant and must not move the index.

// File: rtl/isavar_pkg.sv
package isavar_pkg;
  localparam logic [11:0] CSR_VENDOR = 12'hF11;
  localparam logic [11:0] CSR_ARCH   = 12'hF12;
  localparam logic [11:0] CSR_MVEC   = 12'h305;
  localparam logic [11:0] CSR_SVEC   = 12'h105;

  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_PEND  = 2'd1,
    SW_DRAIN = 2'd2
  } sw_state_e;
endpackage

// File: rtl/isavar_tuple_lut.sv
module isavar_tuple_lut #(
  parameter int unsigned NUM  = 4,
  parameter int unsigned XLEN = 32,
  parameter logic [NUM*XLEN-1:0] VENDOR_TBL = '0,
  parameter logic [NUM*XLEN-1:0] ARCH_TBL   = '0,
  localparam int unsigned IDXW = $clog2(NUM)
) (
  input  logic [XLEN-1:0] vendor_i,
  input  logic [XLEN-1:0] arch_i,
  output logic            hit_o,
  output logic [IDXW-1:0] idx_o,
  input  logic [IDXW-1:0] rd_idx_i,
  output logic [XLEN-1:0] rd_vendor_o,
  output logic [XLEN-1:0] rd_arch_o
);
  logic [NUM-1:0] match;

  for (genvar g = 0; g < NUM; g++) begin : g_cmp
    assign match[g] = (vendor_i == VENDOR_TBL[g*XLEN +: XLEN]) &&
                      (arch_i   == ARCH_TBL[g*XLEN +: XLEN]);
  end

  assign hit_o = |match;

  // lowest matching index wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (match[i]) idx_o = IDXW'(i);
    end
  end

  assign rd_vendor_o = VENDOR_TBL[rd_idx_i*XLEN +: XLEN];
  assign rd_arch_o   = ARCH_TBL[rd_idx_i*XLEN +: XLEN];
endmodule

// File: rtl/isavar_vec_bank.sv
module isavar_vec_bank #(
  parameter int unsigned NUM  = 4,
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] RST_BASE = '0,
  parameter logic [XLEN-1:0] RST_STEP = '0,
  localparam int unsigned IDXW = $clog2(NUM)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IDXW-1:0] sel_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] ent_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[g] <= RST_BASE + XLEN'(g) * RST_STEP;
      end else if (we_i && (sel_i == IDXW'(g))) begin
        ent_q[g] <= {wdata_i[XLEN-1:2], 2'b00};  // direct mode only
      end
    end
  end

  assign rdata_o = ent_q[sel_i];

  // R6
  direct_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[1:0] == 2'b00);
endmodule

// File: rtl/isavar_switch_ctl.sv
module isavar_switch_ctl
  import isavar_pkg::*;
#(
  parameter int unsigned NUM   = 4,
  parameter int unsigned DRAIN = 2,
  localparam int unsigned IDXW = $clog2(NUM),
  localparam int unsigned CW   = $clog2(DRAIN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [IDXW-1:0] start_idx_i,
  input  logic            ready_i,
  output logic [IDXW-1:0] idx_o,
  output logic            stall_o
);
  sw_state_e       state_q;
  logic [IDXW-1:0] pend_q, idx_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SW_IDLE;
      pend_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SW_IDLE: if (start_i) begin
          pend_q  <= start_idx_i;
          state_q <= SW_PEND;
        end
        SW_PEND: if (ready_i) begin
          idx_q   <= pend_q;  // commit; vector set follows the same register
          cnt_q   <= CW'(DRAIN - 1);
          state_q <= SW_DRAIN;
        end
        SW_DRAIN: begin
          if (cnt_q == '0) state_q <= SW_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  assign idx_o   = idx_q;
  assign stall_o = (state_q != SW_IDLE);

  // drain-length observer for the checks below
  logic [7:0] drain_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drain_len_q <= '0;
    else if (state_q == SW_PEND && ready_i) drain_len_q <= '0;
    else if (state_q == SW_DRAIN) drain_len_q <= drain_len_q + 1'b1;
  end

  // R4
  commit_on_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(idx_o) |-> $past(stall_o && ready_i));
  // R4
  drain_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stall_o) |-> drain_len_q == 8'(DRAIN));
endmodule

// File: rtl/isa_variant_csr.sv
module isa_variant_csr
  import isavar_pkg::*;
#(
  parameter int unsigned NUM   = 4,
  parameter int unsigned XLEN  = 32,
  parameter int unsigned DRAIN = 2,
  parameter logic [NUM*XLEN-1:0] VENDOR_TBL =
    {32'h0000_0612, 32'h0000_0489, 32'h0000_0489, 32'h0000_0000},
  parameter logic [NUM*XLEN-1:0] ARCH_TBL =
    {32'h0000_0005, 32'h8000_0002, 32'h0000_0001, 32'h0000_0000},
  parameter logic [XLEN-1:0] MVEC_BASE = 32'h0000_1000,
  parameter logic [XLEN-1:0] SVEC_BASE = 32'h0000_2000,
  parameter logic [XLEN-1:0] VEC_STEP  = 32'h0000_0100,
  localparam int unsigned IDXW = $clog2(NUM)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  input  logic            decode_ready_i,
  input  logic            trap_req_i,
  input  logic            trap_to_s_i,
  output logic            trap_take_o,
  output logic [XLEN-1:0] trap_pc_o,
  output logic [IDXW-1:0] variant_o,
  output logic            stall_o
);
  logic [XLEN-1:0] staged_vendor_q;
  logic            lut_hit;
  logic [IDXW-1:0] lut_idx, act_idx;
  logic [XLEN-1:0] act_vendor, act_arch, mvec, svec;
  logic            arch_wr, vendor_wr, sw_start, stall;

  assign vendor_wr = csr_we_i && (csr_addr_i == CSR_VENDOR) && !stall;
  assign arch_wr   = csr_we_i && (csr_addr_i == CSR_ARCH)   && !stall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        staged_vendor_q <= '0;
    else if (vendor_wr) staged_vendor_q <= csr_wdata_i;
  end

  isavar_tuple_lut #(
    .NUM(NUM), .XLEN(XLEN), .VENDOR_TBL(VENDOR_TBL), .ARCH_TBL(ARCH_TBL)
  ) i_lut (
    .vendor_i    (staged_vendor_q),
    .arch_i      (csr_wdata_i),
    .hit_o       (lut_hit),
    .idx_o       (lut_idx),
    .rd_idx_i    (act_idx),
    .rd_vendor_o (act_vendor),
    .rd_arch_o   (act_arch)
  );

  assign sw_start = arch_wr && lut_hit;  // unsupported pair: dropped

  isavar_switch_ctl #(.NUM(NUM), .DRAIN(DRAIN)) i_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (sw_start),
    .start_idx_i (lut_idx),
    .ready_i     (decode_ready_i),
    .idx_o       (act_idx),
    .stall_o     (stall)
  );

  isavar_vec_bank #(
    .NUM(NUM), .XLEN(XLEN), .RST_BASE(MVEC_BASE), .RST_STEP(VEC_STEP)
  ) i_mvec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (act_idx),
    .we_i    (csr_we_i && (csr_addr_i == CSR_MVEC)),
    .wdata_i (csr_wdata_i),
    .rdata_o (mvec)
  );

  isavar_vec_bank #(
    .NUM(NUM), .XLEN(XLEN), .RST_BASE(SVEC_BASE), .RST_STEP(VEC_STEP)
  ) i_svec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (act_idx),
    .we_i    (csr_we_i && (csr_addr_i == CSR_SVEC)),
    .wdata_i (csr_wdata_i),
    .rdata_o (svec)
  );

  always_comb begin
    unique case (csr_addr_i)
      CSR_VENDOR: csr_rdata_o = act_vendor;
      CSR_ARCH:   csr_rdata_o = act_arch;
      CSR_MVEC:   csr_rdata_o = mvec;
      CSR_SVEC:   csr_rdata_o = svec;
      default:    csr_rdata_o = '0;
    endcase
  end

  // trap gating: one request held across a switch
  logic trap_pend_q, trap_pend_s_q, take, take_s;

  assign take   = !stall && (trap_req_i || trap_pend_q);
  assign take_s = trap_pend_q ? trap_pend_s_q : trap_to_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_pend_q   <= 1'b0;
      trap_pend_s_q <= 1'b0;
    end else if (stall && trap_req_i && !trap_pend_q) begin
      trap_pend_q   <= 1'b1;
      trap_pend_s_q <= trap_to_s_i;
    end else if (take && trap_pend_q) begin
      trap_pend_q   <= 1'b0;
    end
  end

  assign trap_take_o = take;
  assign trap_pc_o   = take_s ? svec : mvec;
  assign variant_o   = act_idx;
  assign stall_o     = stall;

  // R9
  no_trap_in_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_take_o |-> !stall_o);
  // R10
  trap_keeps_variant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_take_o |=> $stable(variant_o));
  // R3
  bad_pair_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_addr_i == CSR_ARCH && !stall_o && !lut_hit) |=> !stall_o);
  // R2
  stall_holds_variant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !decode_ready_i) |=> $stable(variant_o));
endmodule

// File: tb/test_isa_variant_csr.sv
`timescale 1ns/1ps
module test_isa_variant_csr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        csr_we_i = 1'b0;
  logic [11:0] csr_addr_i = '0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;
  logic        decode_ready_i = 1'b0;
  logic        trap_req_i = 1'b0;
  logic        trap_to_s_i = 1'b0;
  logic        trap_take_o;
  logic [31:0] trap_pc_o;
  logic [1:0]  variant_o;
  logic        stall_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  isa_variant_csr i_isa_variant_csr (
    .clk_i, .rst_ni, .csr_we_i, .csr_addr_i, .csr_wdata_i, .csr_rdata_o,
    .decode_ready_i, .trap_req_i, .trap_to_s_i, .trap_take_o, .trap_pc_o,
    .variant_o, .stall_o
  );

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{we:1'b0, addr:12'hF11, wdata:32'h0,         exp:32'h0,         req:4'd1},  // R1
    '{we:1'b0, addr:12'hF12, wdata:32'h0,         exp:32'h0,         req:4'd1},  // R1
    '{we:1'b0, addr:12'h305, wdata:32'h0,         exp:32'h0000_1000, req:4'd1},  // R1
    '{we:1'b0, addr:12'h105, wdata:32'h0,         exp:32'h0000_2000, req:4'd1},  // R1
    '{we:1'b1, addr:12'h305, wdata:32'h8000_0123, exp:32'h8000_0120, req:4'd6},  // R6
    '{we:1'b1, addr:12'h105, wdata:32'h0000_4567, exp:32'h0000_4564, req:4'd7},  // R7
    '{we:1'b1, addr:12'hF11, wdata:32'h0000_0489, exp:32'h0,         req:4'd5},  // R5 staged hidden
    '{we:1'b1, addr:12'hF12, wdata:32'h0000_0007, exp:32'h0,         req:4'd3},  // R3 bad pair
    '{we:1'b1, addr:12'h0C0, wdata:32'hFFFF_FFFF, exp:32'h0,         req:4'd5}   // R5 other addr
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    csr_we_i = 1'b1; csr_addr_i = a; csr_wdata_i = d;
    @(negedge clk_i);
    csr_we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    csr_addr_i = a;
    #1 d = csr_rdata_o;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 variant", 32'(variant_o), 32'd0);
    check("R1 stall", 32'(stall_o), 32'd0);
    check("R1 take", 32'(trap_take_o), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].we) wr(TBL[i].addr, TBL[i].wdata);
      rd(TBL[i].addr, r);
      check($sformatf("R%0d vec%0d", TBL[i].req, i), r, TBL[i].exp);
      check($sformatf("R%0d vec%0d stall", TBL[i].req, i), 32'(stall_o), 32'd0);
    end

    // R2: staged vendor 0x489 + arch 1 -> index 1
    wr(12'hF12, 32'h1);
    check("R2 stall raised", 32'(stall_o), 32'd1);
    check("R2 variant held", 32'(variant_o), 32'd0);
    // R12: identifier writes during the stall are dropped
    wr(12'hF12, 32'h8000_0002);
    wr(12'hF11, 32'h0000_0612);
    check("R2 still waiting", 32'(variant_o), 32'd0);
    // R9: trap during the switch is held
    @(negedge clk_i);
    trap_req_i = 1'b1; trap_to_s_i = 1'b1;
    #1 check("R9 no take in stall", 32'(trap_take_o), 32'd0);
    @(negedge clk_i);
    trap_req_i = 1'b0; trap_to_s_i = 1'b0; decode_ready_i = 1'b1;
    @(negedge clk_i);
    decode_ready_i = 1'b0;
    check("R4 commit", 32'(variant_o), 32'd1);
    check("R4 drain 1", 32'(stall_o), 32'd1);
    check("R9 drain 1 no take", 32'(trap_take_o), 32'd0);
    @(negedge clk_i);
    check("R4 drain 2", 32'(stall_o), 32'd1);
    @(negedge clk_i);
    check("R4 stall drop", 32'(stall_o), 32'd0);
    check("R9 deferred take", 32'(trap_take_o), 32'd1);
    check("R9 deferred pc", trap_pc_o, 32'h0000_2100);
    @(negedge clk_i);
    check("R9 single take", 32'(trap_take_o), 32'd0);
    check("R10 after deferred", 32'(variant_o), 32'd1);

    rd(12'hF11, r); check("R5 vendor", r, 32'h0000_0489);
    rd(12'hF12, r); check("R12 arch", r, 32'h0000_0001);
    rd(12'h305, r); check("R6 bank1 m", r, 32'h0000_1100);
    rd(12'h105, r); check("R7 bank1 s", r, 32'h0000_2100);
    wr(12'h305, 32'h0000_9003);
    rd(12'h305, r); check("R6 bank1 write", r, 32'h0000_9000);

    // R12: staged vendor still 0x489, so (0x489,5) is unsupported
    wr(12'hF12, 32'h5);
    check("R12 staged vendor kept", 32'(stall_o), 32'd0);
    check("R3 variant kept", 32'(variant_o), 32'd1);

    // back to index 0 with ready already high
    decode_ready_i = 1'b1;
    wr(12'hF11, 32'h0);
    wr(12'hF12, 32'h0);
    repeat (3) @(negedge clk_i);
    decode_ready_i = 1'b0;
    check("R4 back to 0", 32'(variant_o), 32'd0);
    check("R4 stall clear", 32'(stall_o), 32'd0);
    rd(12'h305, r); check("R11 bank0 m kept", r, 32'h8000_0120);
    rd(12'h105, r); check("R11 bank0 s kept", r, 32'h0000_4564);

    // R8: immediate traps
    @(negedge clk_i);
    trap_req_i = 1'b1; trap_to_s_i = 1'b0;
    #1 check("R8 take m", 32'(trap_take_o), 32'd1);
    check("R8 pc m", trap_pc_o, 32'h8000_0120);
    trap_to_s_i = 1'b1;
    #1 check("R8 pc s", trap_pc_o, 32'h0000_4564);
    @(negedge clk_i);
    trap_req_i = 1'b0; trap_to_s_i = 1'b0;
    check("R10 after take", 32'(variant_o), 32'd0);

    // index 3 and back-check of bank 1
    decode_ready_i = 1'b1;
    wr(12'hF11, 32'h0000_0612);
    wr(12'hF12, 32'h5);
    repeat (3) @(negedge clk_i);
    check("R2 to index 3", 32'(variant_o), 32'd3);
    rd(12'hF11, r); check("R5 vendor 3", r, 32'h0000_0612);
    rd(12'hF12, r); check("R5 arch 3", r, 32'h0000_0005);
    rd(12'h305, r); check("R6 bank3 m", r, 32'h0000_1300);
    wr(12'hF11, 32'h0000_0489);
    wr(12'hF12, 32'h1);
    repeat (3) @(negedge clk_i);
    decode_ready_i = 1'b0;
    check("R11 back to 1", 32'(variant_o), 32'd1);
    rd(12'h305, r); check("R11 bank1 m kept", r, 32'h0000_9000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule